// File: doc/BRIEF.md
# CRC32C Multi-Width Accumulate Unit

This unit performs one accumulate step of a CRC32C (Castagnoli) checksum. The caller gives it a running 32-bit CRC and a raw data operand that is 1, 2, 4 or 8 bytes wide. Some cycles later the unit returns the updated CRC. It is meant to sit behind an instruction-style front end. That front end has already conditioned the CRC, so the unit applies no inversion at either end. Decode, operand fetch and writeback stay outside the unit.

The datapath is a reflected, right-shifting serial engine. It retires `STEP_BITS` bits per clock. The operand is first masked to its width and XORed into the low end of the accumulator. The engine then shifts the accumulator once for each operand bit. Whenever the bit shifted out is 1, the engine folds in the reflected polynomial 0x82F63B78. An 8-byte operand runs as two 32-bit passes: the low half first, then the high half XORed into the CRC that the first pass produced. A busy output tells the caller when a new request would be dropped.

Top module: `crc32c_accum`

## Requirements
- R1: While reset is held and after it is released, `done_o` and `busy_o` are 0 and `crc_o` is 0.
- R2: Size code 2'b00 (byte) gives the CRC of `crc_i[31:0] ^ data_i[7:0]` after 8 reflected shift steps with polynomial 0x82F63B78. Data bits 63:8 have no effect.
- R3: Size code 2'b01 (word) uses `data_i[15:0]` and 16 shift steps. Data bits 63:16 have no effect.
- R4: Size code 2'b10 (doubleword) uses `data_i[31:0]` and 32 shift steps. Data bits 63:32 have no effect.
- R5: Size code 2'b11 (quadword) runs a 32-bit pass on `data_i[31:0]`. It then runs a second 32-bit pass that starts from the first pass's result XORed with `data_i[63:32]`.
- R6: Bits 63:32 of `crc_i` have no effect on the result.
- R7: A start taken while idle raises `busy_o` on the next cycle. `done_o` pulses for exactly one cycle, `operand_bits / STEP_BITS` cycles after the accepting edge, and `busy_o` is low in the done cycle.
- R8: A start raised while `busy_o` is high is ignored: the pending result is unchanged and no extra done pulse appears.
- R9: `crc_wide_o` equals `crc_o` zero-extended to 64 bits.
- R10: No inversion is applied inside the unit. Feeding the bytes of "123456789" with an external initial value of 0xFFFFFFFF and an external final inversion yields 0xE3069283.
- R11: `crc_o` changes only in a cycle where `done_o` is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, taken when `busy_o` is low |
| size_i | input | 2 | Operand size: 00 byte, 01 word, 10 doubleword, 11 quadword |
| crc_i | input | 64 | Running CRC; only bits 31:0 are used |
| data_i | input | 64 | Raw data operand |
| busy_o | output | 1 | Unit is processing a request |
| done_o | output | 1 | One-cycle result strobe |
| crc_o | output | 32 | Updated CRC |
| crc_wide_o | output | 64 | Updated CRC zero-extended |

## Verification
The bench drives every size with patterns that put ones in the data bits above the operand width and in the upper half of the CRC input. A unit that masked wrongly would return a different CRC for those patterns. For quadword operands it checks the second-pass injection, which a broken sequencer would skip or apply to the wrong half. It fires a start in the middle of a busy run: a unit that honours it would overwrite the pending result or emit two done pulses. The well-known check value confirms that no inversion slipped inside the unit and that chained byte steps compose correctly.

// File: rtl/crc32c_pkg.sv
package crc32c_pkg;

  localparam logic [31:0] CRC_POLY_REFL = 32'h82F63B78;

  typedef enum logic [1:0] {
    OPSZ_BYTE  = 2'b00,
    OPSZ_WORD  = 2'b01,
    OPSZ_DWORD = 2'b10,
    OPSZ_QWORD = 2'b11
  } opsize_e;

  // Clear operand bits above the width of one pass (quad uses low half first).
  function automatic logic [31:0] mask_operand(input opsize_e sz, input logic [31:0] d);
    logic [31:0] m;
    case (sz)
      OPSZ_BYTE: m = {24'h0, d[7:0]};
      OPSZ_WORD: m = {16'h0, d[15:0]};
      default:   m = d;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/crc32c_rst_sync.sv
module crc32c_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/crc32c_step_net.sv
module crc32c_step_net
  import crc32c_pkg::*;
#(
  parameter int STEP_BITS = 4
) (
  input  logic [31:0] acc_in,
  output logic [31:0] acc_out
);

  logic [31:0] chain [STEP_BITS+1];

  assign chain[0] = acc_in;

  for (genvar g = 0; g < STEP_BITS; g++) begin : g_bit
    always_comb begin
      if (chain[g][0]) chain[g+1] = (chain[g] >> 1) ^ CRC_POLY_REFL;
      else             chain[g+1] = chain[g] >> 1;
    end
  end

  assign acc_out = chain[STEP_BITS];

endmodule

// File: rtl/crc32c_seq_ctrl.sv
module crc32c_seq_ctrl
  import crc32c_pkg::*;
#(
  parameter int STEP_BITS = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  opsize_e size,
  output logic    busy,
  output logic    load,
  output logic    step,
  output logic    inject_hi,
  output logic    finish
);

  localparam int CYC8  = 8  / STEP_BITS;
  localparam int CYC16 = 16 / STEP_BITS;
  localparam int CYC32 = 32 / STEP_BITS;
  localparam int CNT_W = $clog2(CYC32) + 1;

  logic             run_q, run_d;
  logic             second_q, second_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             last_beat;

  function automatic logic [CNT_W-1:0] first_count(input opsize_e sz);
    case (sz)
      OPSZ_BYTE: return CNT_W'(CYC8 - 1);
      OPSZ_WORD: return CNT_W'(CYC16 - 1);
      default:   return CNT_W'(CYC32 - 1);
    endcase
  endfunction

  assign busy      = run_q;
  assign load      = start && !run_q;
  assign step      = run_q;
  assign last_beat = run_q && (cnt_q == '0);
  assign inject_hi = last_beat && second_q;
  assign finish    = last_beat && !second_q;

  always_comb begin
    run_d    = run_q;
    second_d = second_q;
    cnt_d    = cnt_q;
    if (load) begin
      run_d    = 1'b1;
      second_d = (size == OPSZ_QWORD);
      cnt_d    = first_count(size);
    end else if (run_q) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end else if (second_q) begin
        second_d = 1'b0;
        cnt_d    = CNT_W'(CYC32 - 1);
      end else begin
        run_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      second_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      run_q    <= run_d;
      second_q <= second_d;
      cnt_q    <= cnt_d;
    end
  end

endmodule

// File: rtl/crc32c_accum.sv
module crc32c_accum
  import crc32c_pkg::*;
#(
  parameter int STEP_BITS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic [1:0]  size_i,
  input  logic [63:0] crc_i,
  input  logic [63:0] data_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [31:0] crc_o,
  output logic [63:0] crc_wide_o
);

  logic        rst_n_int;
  logic        load, step, inject_hi, finish;
  logic [31:0] acc_q, acc_d, net_out;
  logic [31:0] hi_q, hi_d;
  logic [31:0] res_q, res_d;
  logic        done_q, done_d;
  logic        acc_en, hi_en, res_en;
  opsize_e     size;

  assign size = opsize_e'(size_i);

  crc32c_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  crc32c_seq_ctrl #(.STEP_BITS(STEP_BITS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .start     (start_i),
    .size      (size),
    .busy      (busy_o),
    .load      (load),
    .step      (step),
    .inject_hi (inject_hi),
    .finish    (finish)
  );

  crc32c_step_net #(.STEP_BITS(STEP_BITS)) u_net (
    .acc_in  (acc_q),
    .acc_out (net_out)
  );

  // Next-state logic with explicit enables
  always_comb begin
    acc_en = load || step;
    hi_en  = load;
    res_en = finish;
    hi_d   = data_i[63:32];
    res_d  = net_out;
    done_d = finish;
    if (load)           acc_d = crc_i[31:0] ^ mask_operand(size, data_i[31:0]);
    else if (inject_hi) acc_d = net_out ^ hi_q;
    else                acc_d = net_out;
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      acc_q  <= '0;
      hi_q   <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (acc_en) acc_q <= acc_d;
      if (hi_en)  hi_q  <= hi_d;
      if (res_en) res_q <= res_d;
      done_q <= done_d;
    end
  end

  assign done_o     = done_q;
  assign crc_o      = res_q;
  assign crc_wide_o = {32'h0, res_q};

endmodule

// File: rtl/crc32c_accum_chk.sv
module crc32c_accum_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_i,
  input logic        busy_o,
  input logic        done_o,
  input logic [31:0] crc_o,
  input logic [63:0] crc_wide_o
);

  // R7: the done strobe never lasts two cycles
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R7: the unit is idle in the done cycle
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

  // R7: a start taken while idle makes the unit busy
  p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  // R7: busy only ends with a result
  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);

  // R8: a start while busy neither ends the run nor yields a result early
  p_busy_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !done_o) |=> (busy_o || done_o));

  // R11: the result changes only with a done strobe
  p_hold_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(crc_o) |-> done_o);

  // R9: the upper half of the wide result stays zero
  p_wide_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
    crc_wide_o[63:32] == 32'h0);

endmodule

bind crc32c_accum crc32c_accum_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .crc_o      (crc_o),
  .crc_wide_o (crc_wide_o)
);

// File: tb/crc32c_accum_tb.sv
module crc32c_accum_tb;

  localparam int CLK_PERIOD = 10;
  localparam int STEP_BITS  = 4;

  logic        clk;
  logic        rst_n;
  logic        start_i;
  logic [1:0]  size_i;
  logic [63:0] crc_i;
  logic [63:0] data_i;
  logic        busy_o;
  logic        done_o;
  logic [31:0] crc_o;
  logic [63:0] crc_wide_o;

  int checks;
  int failures;

  crc32c_accum #(.STEP_BITS(STEP_BITS)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .size_i     (size_i),
    .crc_i      (crc_i),
    .data_i     (data_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .crc_o      (crc_o),
    .crc_wide_o (crc_wide_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_pass(input logic [31:0] c, input logic [31:0] d, input int nbits);
    logic [31:0] a;
    logic [31:0] m;
    m = (nbits == 32) ? 32'hFFFF_FFFF : ((32'h1 << nbits) - 32'h1);
    a = c ^ (d & m);
    for (int i = 0; i < nbits; i++)
      a = a[0] ? ((a >> 1) ^ 32'h82F63B78) : (a >> 1);
    return a;
  endfunction

  function automatic logic [31:0] ref_crc(input logic [1:0] sz, input logic [63:0] c, input logic [63:0] d);
    case (sz)
      2'b00:   return ref_pass(c[31:0], d[31:0], 8);
      2'b01:   return ref_pass(c[31:0], d[31:0], 16);
      2'b10:   return ref_pass(c[31:0], d[31:0], 32);
      default: return ref_pass(ref_pass(c[31:0], d[31:0], 32), d[63:32], 32);
    endcase
  endfunction

  function automatic int op_cycles(input logic [1:0] sz);
    case (sz)
      2'b00:   return 8 / STEP_BITS;
      2'b01:   return 16 / STEP_BITS;
      2'b10:   return 32 / STEP_BITS;
      default: return 64 / STEP_BITS;
    endcase
  endfunction

  // Issue one request and check latency, busy, result and wide result.
  task automatic run_op(input logic [1:0] sz, input logic [63:0] c, input logic [63:0] d,
                        input string tag, output logic [31:0] res);
    int lat;
    lat = 0;
    @(negedge clk);
    start_i = 1'b1; size_i = sz; crc_i = c; data_i = d;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o === 1'b1, "R7 busy after accept", 64'(busy_o), 64'h1);
    for (int k = 1; k <= 200; k++) begin
      if (done_o === 1'b1) begin lat = k - 1; break; end
      @(negedge clk);
    end
    check(lat == op_cycles(sz), "R7 latency", 64'(lat), 64'(op_cycles(sz)));
    check(busy_o === 1'b0, "R7 idle at done", 64'(busy_o), 64'h0);
    check(crc_o === ref_crc(sz, c, d), tag, 64'(crc_o), 64'(ref_crc(sz, c, d)));
    check(crc_wide_o === {32'h0, crc_o}, "R9 wide result", crc_wide_o, {32'h0, crc_o});
    res = crc_o;
    @(negedge clk);
    check(done_o === 1'b0, "R7 single-cycle done", 64'(done_o), 64'h0);
    check(crc_o === res, "R11 result held", 64'(crc_o), 64'(res));
  endtask

  task automatic t_reset();
    start_i = 1'b0; size_i = 2'b00; crc_i = '0; data_i = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(done_o === 1'b0 && busy_o === 1'b0 && crc_o === 32'h0, "R1 in reset",
          {crc_o, 30'h0, busy_o, done_o}, 64'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(done_o === 1'b0 && busy_o === 1'b0 && crc_o === 32'h0, "R1 after reset",
          {crc_o, 30'h0, busy_o, done_o}, 64'h0);
  endtask

  task automatic t_byte();
    logic [31:0] r;
    run_op(2'b00, 64'h0, 64'h0, "R2 byte zero", r);
    run_op(2'b00, 64'h0000_0000_1234_5678, 64'hFFFF_FFFF_FFFF_FF5A, "R2 byte upper data ignored", r);
    run_op(2'b00, 64'h0, 64'h0000_0000_0000_0001, "R2 byte single bit", r);
  endtask

  task automatic t_word();
    logic [31:0] r;
    run_op(2'b01, 64'h0000_0000_DEAD_BEEF, 64'hAAAA_AAAA_AAAA_1234, "R3 word upper data ignored", r);
    run_op(2'b01, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_FFFF, "R3 word ones", r);
  endtask

  task automatic t_dword();
    logic [31:0] r;
    run_op(2'b10, 64'h0000_0000_0BAD_F00D, 64'h5555_5555_CAFE_BABE, "R4 dword upper data ignored", r);
    run_op(2'b10, 64'h0, 64'h0000_0000_8000_0000, "R4 dword top bit", r);
  endtask

  task automatic t_quad();
    logic [31:0] r;
    run_op(2'b11, 64'h0000_0000_1357_9BDF, 64'h0123_4567_89AB_CDEF, "R5 quad two passes", r);
    run_op(2'b11, 64'h0, 64'hFFFF_FFFF_0000_0000, "R5 quad high half only", r);
  endtask

  task automatic t_upper_crc();
    logic [31:0] r1;
    logic [31:0] r2;
    run_op(2'b10, 64'h0000_0000_ABCD_0123, 64'h0000_0000_7777_1111, "R6 baseline", r1);
    run_op(2'b10, 64'hFFFF_FFFF_ABCD_0123, 64'h0000_0000_7777_1111, "R6 upper crc set", r2);
    check(r1 === r2, "R6 upper crc bits ignored", 64'(r2), 64'(r1));
  endtask

  task automatic t_busy_ignore();
    logic [63:0] ca, da;
    logic [31:0] exp;
    int dones;
    ca = 64'h0000_0000_2468_ACE0; da = 64'h1111_2222_3333_4444;
    exp = ref_crc(2'b11, ca, da);
    dones = 0;
    @(negedge clk);
    start_i = 1'b1; size_i = 2'b11; crc_i = ca; data_i = da;
    @(negedge clk);
    start_i = 1'b0;
    repeat (2) @(negedge clk);
    start_i = 1'b1; size_i = 2'b00; crc_i = 64'hFFFF_FFFF; data_i = 64'hFF;
    @(negedge clk);
    start_i = 1'b0; crc_i = '0; data_i = '0;
    for (int k = 0; k < op_cycles(2'b11) + 4; k++) begin
      if (done_o === 1'b1) dones++;
      @(negedge clk);
    end
    check(dones == 1, "R8 one done for busy start", 64'(dones), 64'h1);
    check(crc_o === exp, "R8 result unchanged by busy start", 64'(crc_o), 64'(exp));
    check(busy_o === 1'b0, "R8 no hidden run", 64'(busy_o), 64'h0);
  endtask

  task automatic t_check_value();
    logic [31:0] acc;
    logic [31:0] r;
    logic [7:0]  msg [9];
    for (int i = 0; i < 9; i++) msg[i] = 8'h31 + 8'(i);
    acc = 32'hFFFF_FFFF;
    for (int i = 0; i < 9; i++) begin
      run_op(2'b00, {32'h0, acc}, {56'h0, msg[i]}, "R10 check-value byte step", r);
      acc = r;
    end
    check((acc ^ 32'hFFFF_FFFF) === 32'hE3069283, "R10 check value bytewise",
          64'(acc ^ 32'hFFFF_FFFF), 64'hE3069283);
    run_op(2'b11, 64'hFFFF_FFFF, 64'h3837_3635_3433_3231, "R10 check-value quad step", r);
    run_op(2'b00, {32'h0, r}, 64'h39, "R10 check-value tail", r);
    check((r ^ 32'hFFFF_FFFF) === 32'hE3069283, "R10 check value quad+byte",
          64'(r ^ 32'hFFFF_FFFF), 64'hE3069283);
  endtask

  initial begin
    checks = 0;
    failures = 0;
    t_reset();
    t_byte();
    t_word();
    t_dword();
    t_quad();
    t_upper_crc();
    t_busy_ignore();
    t_check_value();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R7 watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule